// File: doc/BRIEF.md
# Transmit Input Latch with FIFO Prefetch

This block is the input stage of a serial word transmitter. It holds one word, together with the word-identifier bit that goes with it, until the serializer downstream takes it. The word reaches the latch in one of two ways. A host write strobe can load it directly. Otherwise the block fetches it from an external FIFO, using an active-low read strobe that the block generates itself.

While the FIFO enable is high and the latch is empty, the block pulls one word from the FIFO. It does not request another word until the serializer has accepted the current one. Holding the enable high therefore streams words one per accept (burst). A short pulse on the enable fetches exactly one word (single word).

A master reset returns the sequencing to idle and clears the flags. It leaves the stored word itself untouched.

Top module: `tx_input_stage`

## Requirements
- R1: `rdy_for_data` is 1 exactly when the latch is empty, and `ser_valid` is its inverse. After reset, `rdy_for_data`=1 and `ser_valid`=0.
- R2: When `fifo_en` is high, the latch is empty and no read is in progress, `fifo_rd_n` goes low in the following cycle for exactly one cycle.
- R3: The values on `bus_data` and `word_id_in` during the cycle in which `fifo_rd_n` is low are stored in the latch at the end of that cycle. `ser_valid` is 1 in the next cycle.
- R4: `ser_word_id` presents the stored identifier bit: 0 marks a data word and 1 marks a command/interrupt word.
- R5: While `ser_valid`=1 and `ser_ready`=0, `ser_data` and `ser_word_id` stay unchanged. A clock edge with both signals high empties the latch.
- R6: If `fifo_en` is high for a single cycle while the latch is empty, exactly one FIFO read results.
- R7: While the latch is full, no FIFO read is issued. With `fifo_en` held high, reads occur at most once per serializer accept.
- R8: A `host_wr` pulse with `fifo_en`=0 and an empty latch stores `bus_data`/`word_id_in` at that clock edge.
- R9: A `host_wr` with `fifo_en`=0 while the latch is full or a FIFO read is in progress is ignored: the stored word is unchanged. It also sets `busy_flag`, which stays at 1 until reset.
- R10: A `host_wr` while `fifo_en`=1 has no effect on the latch and does not set `busy_flag`.
- R11: A synchronous active-low reset clears the full state, any pending read and `busy_flag`. It keeps the stored word, which remains visible on `ser_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| fifo_en | input | 1 | Enables automatic fetching from the external FIFO |
| host_wr | input | 1 | Host write strobe, active high |
| bus_data | input | DATA_W | Parallel word bus, driven by the host or the FIFO |
| word_id_in | input | 1 | Identifier bit for the word on the bus |
| fifo_rd_n | output | 1 | Active-low FIFO read strobe |
| rdy_for_data | output | 1 | Latch empty |
| busy_flag | output | 1 | Sticky flag: a host write was rejected |
| ser_valid | output | 1 | A word is available to the serializer |
| ser_ready | input | 1 | Serializer accepts the word |
| ser_data | output | DATA_W | Stored word |
| ser_word_id | output | 1 | Stored identifier bit |

## Verification
A wrong full state appears in the very next cycle, in one of three ways: `rdy_for_data` and `ser_valid` disagree with the load and accept history, an extra read strobe appears, or an expected strobe is missing. A corrupted capture shows up at the next accept, when the scoreboard compares the word and identifier bit against the one the FIFO model or host delivered. A stuck or wrongly set busy flag is visible on its port one cycle after the write that should, or should not, have set it.

// File: rtl/tx_in_pkg.sv
// Package: shared types for the transmit input stage.
// Assumes nothing beyond standard SystemVerilog packed types.
package tx_in_pkg;

    // Outcome of a host write request in one cycle.
    typedef enum logic [1:0] {
        HW_NONE    = 2'd0,
        HW_LOAD    = 2'd1,
        HW_REJECT  = 2'd2,
        HW_IGNORED = 2'd3
    } host_wr_e;

endpackage

// File: rtl/fifo_fetch_ctl.sv
// Module: fifo_fetch_ctl
// Issues a one-cycle FIFO read when fetching is enabled and the latch is
// empty. Assumes the latch reports full starting the cycle after a read.
module fifo_fetch_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_en,
    input  logic latch_full,
    output logic rd_active,
    output logic fifo_rd_n
);

    logic rd_q;

    // Arm the read one cycle after the request conditions hold; never twice in a row.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= fifo_en && !latch_full && !rd_q;
    end

    assign rd_active = rd_q;
    assign fifo_rd_n = !rd_q;

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |=> !rd_q); // R2
    AST_NO_READ_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |-> !latch_full); // R7

endmodule

// File: rtl/host_wr_gate.sv
// Module: host_wr_gate
// Decides whether a host write loads the latch, is rejected (sticky busy)
// or is ignored because FIFO fetching is enabled.
module host_wr_gate
    import tx_in_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_wr,
    input  logic fifo_en,
    input  logic latch_full,
    input  logic rd_active,
    output logic load_host,
    output logic busy_flag
);

    host_wr_e outcome;
    logic     busy_q;

    // Classify this cycle's host write.
    always_comb begin
        if (!host_wr)                      outcome = HW_NONE;
        else if (fifo_en)                  outcome = HW_IGNORED;
        else if (latch_full || rd_active)  outcome = HW_REJECT;
        else                               outcome = HW_LOAD;
    end

    assign load_host = (outcome == HW_LOAD);

    // Sticky busy: set on a rejected write, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                    busy_q <= 1'b0;
        else if (outcome == HW_REJECT) busy_q <= 1'b1;
    end

    assign busy_flag = busy_q;

    AST_BUSY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> busy_q); // R9

endmodule

// File: rtl/word_latch.sv
// Module: word_latch
// Single-word store with full flag and valid/accept handoff. The stored
// word has no reset so a master reset keeps it. Assumes loads only arrive
// while the latch is empty.
module word_latch #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_wid,
    input  logic              ser_ready,
    output logic              full,
    output logic [DATA_W-1:0] out_data,
    output logic              out_wid
);

    logic              full_q;
    logic [DATA_W-1:0] data_q;
    logic              wid_q;

    // Occupancy: set on load, cleared on accept.
    always_ff @(posedge clk) begin
        if (!rst_n)                  full_q <= 1'b0;
        else if (load)               full_q <= 1'b1;
        else if (full_q && ser_ready) full_q <= 1'b0;
    end

    // Word storage, deliberately outside reset.
    always_ff @(posedge clk) begin
        if (load) begin
            data_q <= in_data;
            wid_q  <= in_wid;
        end
    end

    assign full     = full_q;
    assign out_data = data_q;
    assign out_wid  = wid_q;

    AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> full_q); // R3
    AST_HOLD_UNTIL_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        full_q && !ser_ready |=> full_q && $stable(data_q) && $stable(wid_q)); // R5
    AST_NO_LOAD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |-> !load); // R9

endmodule

// File: rtl/tx_input_stage.sv
// Module: tx_input_stage (top)
// Transmit input latch fed by host writes or automatic FIFO reads, handing
// words to a serializer through valid/accept. Reset keeps the stored word.
module tx_input_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              word_id_in,
    output logic              fifo_rd_n,
    output logic              rdy_for_data,
    output logic              busy_flag,
    output logic              ser_valid,
    input  logic              ser_ready,
    output logic [DATA_W-1:0] ser_data,
    output logic              ser_word_id
);

    logic full;
    logic rd_active;
    logic load_host;
    logic load_any;

    fifo_fetch_ctl u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .latch_full (full),
        .rd_active  (rd_active),
        .fifo_rd_n  (fifo_rd_n)
    );

    host_wr_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .fifo_en    (fifo_en),
        .latch_full (full),
        .rd_active  (rd_active),
        .load_host  (load_host),
        .busy_flag  (busy_flag)
    );

    // Either source loads the latch; the gate keeps them mutually exclusive.
    assign load_any = rd_active || load_host;

    word_latch #(.DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_any),
        .in_data   (bus_data),
        .in_wid    (word_id_in),
        .ser_ready (ser_ready),
        .full      (full),
        .out_data  (ser_data),
        .out_wid   (ser_word_id)
    );

    assign rdy_for_data = !full;
    assign ser_valid    = full;

    AST_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_active && load_host)); // R9
    AST_READ_THEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_rd_n |=> ser_valid); // R3

endmodule

// File: tb/sim_tx_input_stage.sv
module sim_tx_input_stage;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fifo_en = 1'b0;
    logic         host_wr = 1'b0;
    logic [W-1:0] bus_data;
    logic         word_id_in;
    logic         fifo_rd_n;
    logic         rdy_for_data;
    logic         busy_flag;
    logic         ser_valid;
    logic         ser_ready = 1'b0;
    logic [W-1:0] ser_data;
    logic         ser_word_id;

    logic         host_mode = 1'b0;
    logic [W-1:0] host_val = '0;
    logic         host_wid = 1'b0;
    int           fifo_idx = 0;
    int           rd_count = 0;
    int           pop_count = 0;
    int           tests = 0;
    int           fails = 0;
    logic [W:0]   expq[$];

    always #4 clk = ~clk;

    tx_input_stage #(.DATA_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .host_wr(host_wr),
        .bus_data(bus_data), .word_id_in(word_id_in), .fifo_rd_n(fifo_rd_n),
        .rdy_for_data(rdy_for_data), .busy_flag(busy_flag), .ser_valid(ser_valid),
        .ser_ready(ser_ready), .ser_data(ser_data), .ser_word_id(ser_word_id)
    );

    function automatic logic [W-1:0] fifo_word(input int i);
        return W'(16'hA000 + i * 3);
    endfunction

    assign bus_data   = host_mode ? host_val : fifo_word(fifo_idx);
    assign word_id_in = host_mode ? host_wid : fifo_idx[0];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // FIFO model: a read strobe at an edge consumes the current word.
    always @(posedge clk) begin
        if (rst_n && !fifo_rd_n) begin
            expq.push_back({fifo_idx[0], fifo_word(fifo_idx)});
            fifo_idx <= fifo_idx + 1;
            rd_count <= rd_count + 1;
        end
    end

    // Scoreboard monitor: compare each accepted word (R3, R4, R5).
    always @(negedge clk) begin
        if (rst_n && ser_valid && ser_ready) begin
            pop_count++;
            if (expq.size() == 0) check("R5 unexpected accept", 1, 0);
            else begin
                logic [W:0] e;
                e = expq.pop_front();
                check("R3 data", ser_data, e[W-1:0]);
                check("R4 word id", ser_word_id, e[W]);
            end
        end
    end

    task automatic host_write(input logic [W-1:0] v, input logic wid, input bit expect_load);
        host_mode = 1'b1; host_val = v; host_wid = wid; host_wr = 1'b1;
        if (expect_load) expq.push_back({wid, v});
        step();
        host_wr = 1'b0; host_mode = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int r0;
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset rdy", rdy_for_data, 1);
        check("R1 reset valid", ser_valid, 0);
        check("R11 reset busy", busy_flag, 0);
        check("R2 idle strobe", fifo_rd_n, 1);

        // R8 host load, command word
        step();
        host_write(16'h1234, 1'b1, 1);
        @(negedge clk);
        check("R8 valid", ser_valid, 1);
        check("R1 rdy low", rdy_for_data, 0);
        check("R8 data", ser_data, 16'h1234);
        check("R4 wid", ser_word_id, 1);

        // R9 write while full
        step();
        host_write(16'h5555, 1'b0, 0);
        @(negedge clk);
        check("R9 busy", busy_flag, 1);
        check("R9 data kept", ser_data, 16'h1234);
        repeat (3) step();
        @(negedge clk);
        check("R5 held", ser_data, 16'h1234);
        check("R9 busy sticky", busy_flag, 1);

        // R5 accept
        step(); ser_ready = 1'b1;
        step(); ser_ready = 1'b0;
        @(negedge clk);
        check("R5 emptied", rdy_for_data, 1);

        // R2/R3/R6 single-word fetch
        r0 = rd_count;
        step(); fifo_en = 1'b1;
        step(); fifo_en = 1'b0;
        @(negedge clk);
        check("R2 strobe low", fifo_rd_n, 0);
        step();
        @(negedge clk);
        check("R2 strobe one cycle", fifo_rd_n, 1);
        check("R3 valid after read", ser_valid, 1);
        check("R3 captured", ser_data, fifo_word(0));
        repeat (4) step();
        check("R6 single read", rd_count - r0, 1);

        // R7 no read while full
        fifo_en = 1'b1;
        repeat (5) step();
        @(negedge clk);
        check("R7 no read full", rd_count - r0, 1);

        // R7 burst
        ser_ready = 1'b1;
        repeat (21) step();
        fifo_en = 1'b0;
        repeat (4) step();
        ser_ready = 1'b0;
        step();
        check("R7 burst reads", (rd_count - r0) >= 6, 1);
        check("R7 one read per accept", rd_count, pop_count - 1);
        check("R7 scoreboard drained", expq.size(), 0);

        // R11 reset keeps stored word
        host_write(16'hBEEF, 1'b0, 0);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 valid cleared", ser_valid, 0);
        check("R11 busy cleared", busy_flag, 0);
        check("R11 data kept", ser_data, 16'hBEEF);

        // R10 write while fetching enabled
        step();
        host_mode = 1'b1; host_val = 16'h7777; host_wr = 1'b1; fifo_en = 1'b1;
        step();
        host_wr = 1'b0; host_mode = 1'b0; fifo_en = 1'b0;
        repeat (2) step();
        @(negedge clk);
        check("R10 no busy", busy_flag, 0);
        check("R10 fifo word", ser_data, fifo_word(fifo_idx - 1));
        step(); ser_ready = 1'b1;
        step(); ser_ready = 1'b0;
        step();
        check("R10 scoreboard drained", expq.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule